// File: doc/BRIEF.md
# Synchronous Presettable Decade Counter

This block is one BCD digit of a synchronous counter. It holds a 4-bit state that steps 0, 1, ..., 9 and then back to 0 on a rising clock edge. It steps only when both count-enable inputs are high. Every state bit is clocked by the same edge, so the four outputs change together.

Two active-low controls act at the clock edge and override the enables:
- a clear, which forces the state to zero;
- a parallel load, which copies a 4-bit data word into the state.

Codes 10 to 15 are not part of the count. A state holding one of them, whether loaded or present at power-up, follows a fixed recovery path back into the normal sequence.

A carry output marks the terminal count. It is gated by the second enable. To build a multi-digit counter, feed each digit's carry into the second enable of the next higher digit. All digits share one clock. The block has no data stream, so every pin is a plain level-sensitive control or status signal with no handshake.

Top module: `bcd_decade_counter`

## Requirements
- R1: With clr_n, load_n, en_par and en_chain all high at a rising edge, q advances by one from 0 through 8, and 9 becomes 0. All four bits of q change only at that edge.
- R2: With clr_n low at a rising edge, q becomes 0000 on that edge, whatever the other inputs are.
- R3: With load_n low and clr_n high at a rising edge, q takes the value of d on that edge, whatever the enables are. Values 10 to 15 are accepted as well.
- R4: When clr_n and load_n are both low at the same edge, the clear wins and q becomes 0000.
- R5: With clr_n and load_n high, q keeps its value at a rising edge if en_par or en_chain is low. This holds for codes 10 to 15 as well.
- R6: On a counting edge, an unused code moves as follows: 10 to 11, 11 to 6, 12 to 13, 13 to 4, 14 to 15, 15 to 2. Every unused code therefore reaches 0 to 9 within two counting edges.
- R7: carry is high exactly when en_chain is high and q equals 9. It follows those two signals combinationally, without waiting for a clock edge.
- R8: Two stages on one clock form a 00 to 99 counter that wraps to 00. The upper stage has its en_chain driven by the lower stage's carry, and both stages share en_par. The upper stage's carry is high only at count 99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes happen on its rising edge. |
| clr_n | input | 1 | Synchronous clear, active low. Highest priority. |
| load_n | input | 1 | Synchronous parallel load, active low. |
| en_par | input | 1 | Count enable that has no effect on carry. |
| en_chain | input | 1 | Count enable that also gates carry. |
| d | input | 4 | Data word copied into the state on a load. |
| q | output | 4 | Current BCD state. |
| carry | output | 1 | Terminal-count flag: en_chain high and q equal to 9. |

## Verification
The cycle that matters is one where clear, load and counting are all requested at the same edge. The bench provokes this by loading each of the sixteen start codes and then applying every one of the sixteen combinations of clr_n, load_n and the two enables, each with several data words. Every edge is judged against an arithmetic model in which clear beats load, and load beats counting. The carry is sampled in the same cycle, before the edge, so that a terminal count that coincides with a clear or load is also checked.

// File: rtl/bcd_counter_pkg.sv
package bcd_counter_pkg;
  localparam int DIGIT_W    = 4;
  localparam int LAST_DIGIT = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // Action taken by the state register at the next rising edge.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;
endpackage

// File: rtl/bcd_op_select.sv
module bcd_op_select
  import bcd_counter_pkg::*;
(
  input  logic clr_n,
  input  logic load_n,
  input  logic en_par,
  input  logic en_chain,
  output op_e  op
);
  // Priority: clear, then load, then count, then hold.
  always_comb begin
    if (!clr_n)                  op = OP_CLEAR;
    else if (!load_n)            op = OP_LOAD;
    else if (en_par && en_chain) op = OP_COUNT;
    else                         op = OP_HOLD;
  end
endmodule

// File: rtl/bcd_step.sv
module bcd_step
  import bcd_counter_pkg::*;
#(
  parameter int LAST = LAST_DIGIT
) (
  input  digit_t cur,
  output digit_t nxt
);
  localparam digit_t LAST_CODE = digit_t'(LAST);

  always_comb begin
    if (cur < LAST_CODE) begin
      nxt = cur + digit_t'(1);
    end else if (cur == LAST_CODE) begin
      nxt = '0;
    end else begin
      // Recovery path for unused codes; at most two steps back into range.
      unique case (cur)
        4'd10:   nxt = 4'd11;
        4'd11:   nxt = 4'd6;
        4'd12:   nxt = 4'd13;
        4'd13:   nxt = 4'd4;
        4'd14:   nxt = 4'd15;
        default: nxt = 4'd2;
      endcase
    end
  end
endmodule

// File: rtl/bcd_carry.sv
module bcd_carry
  import bcd_counter_pkg::*;
#(
  parameter int LAST = LAST_DIGIT
) (
  input  digit_t cur,
  input  logic   en_chain,
  output logic   carry
);
  localparam digit_t LAST_CODE = digit_t'(LAST);

  assign carry = en_chain && (cur == LAST_CODE);
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
  import bcd_counter_pkg::*;
(
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               en_par,
  input  logic               en_chain,
  input  logic [DIGIT_W-1:0] d,
  output logic [DIGIT_W-1:0] q,
  output logic               carry
);
  op_e    op;
  digit_t state_q;
  digit_t step_nxt;

  bcd_op_select u_sel (
    .clr_n    (clr_n),
    .load_n   (load_n),
    .en_par   (en_par),
    .en_chain (en_chain),
    .op       (op)
  );

  bcd_step #(.LAST(LAST_DIGIT)) u_step (
    .cur (state_q),
    .nxt (step_nxt)
  );

  bcd_carry #(.LAST(LAST_DIGIT)) u_carry (
    .cur      (state_q),
    .en_chain (en_chain),
    .carry    (carry)
  );

  always_ff @(posedge clk) begin
    unique case (op)
      OP_CLEAR: state_q <= '0;
      OP_LOAD:  state_q <= d;
      OP_COUNT: state_q <= step_nxt;
      default:  state_q <= state_q;
    endcase
  end

  assign q = state_q;

  // Assertions are armed after two edges, so the power-up contents of the
  // state are never used as a reference.
  logic [1:0] chk_age = 2'd0;
  always_ff @(posedge clk) begin
    if (chk_age != 2'd2) chk_age <= chk_age + 2'd1;
  end
  logic chk_live;
  assign chk_live = (chk_age == 2'd2);

  // R2 R4
  clear_wins_chk: assert property (@(posedge clk) disable iff (!chk_live)
    !clr_n |=> (q == '0));

  // R3
  load_takes_d_chk: assert property (@(posedge clk) disable iff (!chk_live)
    (clr_n && !load_n) |=> (q == $past(d)));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!chk_live)
    (clr_n && load_n && !(en_par && en_chain)) |=> $stable(q));

  // R1
  count_up_chk: assert property (@(posedge clk) disable iff (!chk_live)
    (clr_n && load_n && en_par && en_chain && q < 4'd9) |=> (q == $past(q) + 4'd1));

  // R6
  recover_odd_chk: assert property (@(posedge clk) disable iff (!chk_live)
    (clr_n && load_n && en_par && en_chain && q > 4'd9 && q[0]) |=> (q <= 4'd9));

  // R6
  recover_even_chk: assert property (@(posedge clk) disable iff (!chk_live)
    (clr_n && load_n && en_par && en_chain && q > 4'd9 && !q[0]) |=> (q == $past(q) + 4'd1));

  // R7 R1
  carry_wrap_chk: assert property (@(posedge clk) disable iff (!chk_live)
    (carry && en_par && clr_n && load_n) |=> (q == '0));
endmodule

// File: tb/bcd_decade_counter_test.sv
`timescale 1ns/1ps
module bcd_decade_counter_test;
  logic       clk = 1'b0;
  logic       clr_n, load_n, en_par, en_chain;
  logic [3:0] d;
  logic [3:0] q;
  logic       carry;

  // second digit for the cascade
  logic       hi_clr_n, hi_load_n;
  logic [3:0] hi_q;
  logic       hi_carry;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bcd_decade_counter uut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_chain(en_chain), .d(d), .q(q), .carry(carry)
  );

  bcd_decade_counter uut_hi (
    .clk(clk), .clr_n(hi_clr_n), .load_n(hi_load_n), .en_par(en_par),
    .en_chain(carry), .d(4'd0), .q(hi_q), .carry(hi_carry)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_step(input int v);
    if (v < 9) return v + 1;
    if (v == 9) return 0;
    if (v % 2 == 0) return v + 1;
    return 17 - v;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input bit c, input bit l, input bit p, input bit t, input int dv);
    clr_n = c; load_n = l; en_par = p; en_chain = t; d = dv[3:0];
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_vec++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    hi_clr_n = 1'b0; hi_load_n = 1'b1;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 0);
    tick(); tick();
    // R2 reset state
    check(q == 4'd0, "R2", q, 0);
    check(hi_q == 4'd0, "R2", hi_q, 0);

    // Sweep: every start code x every control combination x several data words.
    for (int s = 0; s < 16; s++) begin
      for (int ctl = 0; ctl < 16; ctl++) begin
        for (int k = 0; k < 4; k++) begin
          int dv, exp_q;
          bit c, l, p, t;
          string req;
          dv = (s * 5 + ctl * 3 + k * 7) % 16;
          drive(1'b1, 1'b0, 1'b0, 1'b0, s);
          tick();
          // R3 load of any code
          check(q == 4'(s), "R3", q, s);
          c = ctl[3]; l = ctl[2]; p = ctl[1]; t = ctl[0];
          drive(c, l, p, t, dv);
          #1;
          // R7 carry, combinational, sampled before the edge
          check(carry == (t && s == 9), "R7", carry, int'(t && s == 9));
          if (!c)            begin exp_q = 0;  req = (!l) ? "R4" : "R2"; end
          else if (!l)       begin exp_q = dv; req = "R3"; end
          else if (p && t)   begin exp_q = model_step(s); req = (s > 9) ? "R6" : "R1"; end
          else               begin exp_q = s;  req = "R5"; end
          tick();
          check(q == 4'(exp_q), req, q, exp_q);
        end
      end
    end

    // R6: each unused code is back in 0..9 within two counting edges
    for (int s = 10; s < 16; s++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, s);
      tick();
      drive(1'b1, 1'b1, 1'b1, 1'b1, 0);
      tick(); tick();
      check(q <= 4'd9, "R6", q, model_step(model_step(s)));
    end

    // R1: full counting loop, two turns
    drive(1'b0, 1'b1, 1'b1, 1'b1, 0);
    tick();
    for (int i = 1; i <= 20; i++) begin
      drive(1'b1, 1'b1, 1'b1, 1'b1, 0);
      tick();
      check(q == 4'(i % 10), "R1", q, i % 10);
    end

    // R8: two-digit cascade 00..99 and wrap
    drive(1'b0, 1'b1, 1'b0, 1'b0, 0);
    hi_clr_n = 1'b0;
    tick();
    hi_clr_n = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 0);
    #1;
    for (int i = 1; i <= 230; i++) begin
      int exp_n;
      tick();
      exp_n = i % 100;
      check(q == 4'(exp_n % 10) && hi_q == 4'(exp_n / 10), "R8",
            int'(hi_q) * 10 + int'(q), exp_n);
      check(hi_carry == (exp_n == 99), "R8", hi_carry, int'(exp_n == 99));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule